// File: doc/BRIEF.md
# Ping-Pong Buffer Status Controller

This block keeps the bookkeeping for two memory buffers that take turns feeding a streaming output. A host fills a buffer in memory, writes its base address and then writes a one to that buffer's acknowledge bit. The acknowledge clears the buffer's empty flag and freezes the base address that a fetch engine will read. The fetch engine reads the current buffer. When it has used the whole buffer it pulses `evt_consumed`. The controller then marks that buffer empty and moves on to the other buffer.

A two-state machine tracks the current buffer. `SERVE_B1` is the reset state. The transition `SWAP_TO_B2` leaves `SERVE_B1` when buffer 1 is consumed while it is filled. The transition `SWAP_TO_B1` returns from `SERVE_B2` when buffer 2 is consumed while it is filled. A `evt_consumed` pulse that arrives while the current buffer is empty is a `HOLD` and causes no transition.

Besides the two empty flags there are two more flags. An underrun flag is set when the engine asks for data from an empty buffer. An error flag is set by an engine error pulse. Each of the four flags has an interrupt enable. The single level interrupt is high while any enabled flag is set.

Top module: `pingpong_buf_ctrl`

## Requirements
- R1: After reset the following hold: both empty flags read 1, the underrun and error flags read 0, all enables read 0, `irq_o` is 0, `fetch_sel` is 0 (buffer 1) and `fetch_valid` is 0.
- R2: A write to address 0 with bit 0 (buffer 1) or bit 1 (buffer 2) set to 1 clears that buffer's empty flag in the same clock edge. A 0 in an acknowledge bit leaves the flag unchanged.
- R3: The read map is as follows. Address 0 returns the enables at bits 7 (underrun), 6 (error), 5 (buffer 2 empty) and 4 (buffer 1 empty), with bits 3:0 always 0. Address 1 returns bit 0 buffer 1 empty, bit 1 buffer 2 empty, bit 2 error, bit 3 underrun and bit 4 the current buffer (0 = buffer 1). All other bits read 0.
- R4: Addresses 2 and 3 hold the base addresses of buffer 1 and buffer 2. Only bits 31:6 are stored, and bits 5:0 always read 0.
- R5: `fetch_addr` shows the base address of the current buffer as it was in the cycle of that buffer's last acknowledge. Later writes to the base register do not change it until the next acknowledge.
- R6: Fetching starts at buffer 1. `evt_consumed` while the current buffer is filled sets that buffer's empty flag and makes the other buffer current. `evt_consumed` while the current buffer is empty has no effect.
- R7: `evt_need` while the current buffer is empty sets the underrun flag.
- R8: `evt_error` sets the error flag. Writing 1 to bit 3 or bit 2 of address 0 clears the underrun or error flag.
- R9: `irq_o` is the OR over the four flags of each flag ANDed with its enable.
- R10: When a hardware set and a host acknowledge hit the same flag in the same cycle, the flag ends up set.
- R11: `fetch_valid` is 1 exactly when the current buffer's empty flag is 0. `fetch_sel` names the current buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| evt_consumed | input | 1 | Pulse: the engine has finished the current buffer |
| evt_need | input | 1 | Pulse: the engine requests data |
| evt_error | input | 1 | Pulse: the engine saw an error |
| fetch_addr | output | 32 | Latched base address of the current buffer |
| fetch_valid | output | 1 | Current buffer is filled |
| fetch_sel | output | 1 | Current buffer (0 = buffer 1, 1 = buffer 2) |
| irq_o | output | 1 | Level interrupt |

## Verification
Host acknowledges and engine events can change the same flag in the same clock cycle. A clear from the host and a set from the engine then compete. The bench forces this on purpose in two cases. In the first, buffer 2 is acknowledged in the same cycle it is reported consumed. In the second, the error flag is acknowledged in the same cycle an error pulse arrives. In both cases the flag must stay set. The random phase then drives writes and events together in most cycles. After every edge it compares the flags, the current buffer and the interrupt against a bench model that lets sets win over clears.

// File: rtl/pp_pkg.sv
package pp_pkg;
    localparam int FLAG_N   = 4;
    localparam int F_EMP1   = 0;
    localparam int F_EMP2   = 1;
    localparam int F_ERR    = 2;
    localparam int F_UDR    = 3;

    localparam logic [1:0] A_CTRL  = 2'd0;
    localparam logic [1:0] A_STAT  = 2'd1;
    localparam logic [1:0] A_BASE1 = 2'd2;
    localparam logic [1:0] A_BASE2 = 2'd3;

    typedef enum logic {
        SERVE_B1 = 1'b0,
        SERVE_B2 = 1'b1
    } pp_state_e;
endpackage

// File: rtl/pp_regs.sv
module pp_regs
    import pp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int ALIGN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     base1,
    output logic [DW-1:0]     base2,
    output logic [FLAG_N-1:0] en,
    output logic [FLAG_N-1:0] ack
);
    localparam int KEEP = DW - ALIGN;

    logic [KEEP-1:0]   base_q [2];
    logic [FLAG_N-1:0] en_q;
    logic              ctrl_wr;

    assign ctrl_wr = wr && (addr == A_CTRL);
    assign ack     = ctrl_wr ? wdata[FLAG_N-1:0] : '0;
    assign en      = en_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (ctrl_wr) begin
            en_q <= wdata[2*FLAG_N-1:FLAG_N];
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_base
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[i] <= '0;
            end else if (wr && (addr == (A_BASE1 + 2'(i)))) begin
                base_q[i] <= wdata[DW-1:ALIGN];
            end
        end
    end

    assign base1 = {base_q[0], {ALIGN{1'b0}}};
    assign base2 = {base_q[1], {ALIGN{1'b0}}};

    p_en_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr |=> $stable(en_q));
endmodule

// File: rtl/pp_flags.sv
module pp_flags
    import pp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set,
    input  logic [FLAG_N-1:0] clr,
    output logic [FLAG_N-1:0] flags
);
    localparam logic [FLAG_N-1:0] RST_VAL = FLAG_N'(4'b0011);

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags[i] <= RST_VAL[i];
            end else if (set[i]) begin
                flags[i] <= 1'b1;
            end else if (clr[i]) begin
                flags[i] <= 1'b0;
            end
        end

        p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
        p_ack_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/pp_seq.sv
module pp_seq
    import pp_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          consumed,
    input  logic          need,
    input  logic [1:0]    emp,
    input  logic [1:0]    ack_buf,
    input  logic [DW-1:0] base1,
    input  logic [DW-1:0] base2,
    output logic [1:0]    set_emp,
    output logic          set_udr,
    output logic          cur_sel,
    output logic [DW-1:0] fetch_addr,
    output logic          fetch_valid
);
    pp_state_e     state_q, state_d;
    logic [DW-1:0] lat_q [2];
    logic          cur_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SERVE_B1;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q[0] <= '0;
            lat_q[1] <= '0;
        end else begin
            if (ack_buf[0]) lat_q[0] <= base1;
            if (ack_buf[1]) lat_q[1] <= base2;
        end
    end

    always_comb begin
        state_d     = state_q;
        set_emp     = 2'b00;
        cur_empty   = 1'b1;
        fetch_addr  = '0;
        cur_sel     = 1'b0;
        unique case (state_q)
            SERVE_B1: begin
                cur_sel    = 1'b0;
                cur_empty  = emp[0];
                fetch_addr = lat_q[0];
                if (consumed && !emp[0]) begin
                    set_emp[0] = 1'b1;
                    state_d    = SERVE_B2;
                end
            end
            SERVE_B2: begin
                cur_sel    = 1'b1;
                cur_empty  = emp[1];
                fetch_addr = lat_q[1];
                if (consumed && !emp[1]) begin
                    set_emp[1] = 1'b1;
                    state_d    = SERVE_B1;
                end
            end
            default: state_d = SERVE_B1;
        endcase
        fetch_valid = !cur_empty;
        set_udr     = need && cur_empty;
    end

    p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (consumed && fetch_valid) |=> (state_q != $past(state_q)));
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> (state_q == $past(state_q)));
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_buf[0] |=> $stable(lat_q[0]));
endmodule

// File: rtl/pingpong_buf_ctrl.sv
module pingpong_buf_ctrl
    import pp_pkg::*;
#(
    parameter int DW    = 32,
    parameter int ALIGN = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          evt_consumed,
    input  logic          evt_need,
    input  logic          evt_error,
    output logic [DW-1:0] fetch_addr,
    output logic          fetch_valid,
    output logic          fetch_sel,
    output logic          irq_o
);
    logic [DW-1:0]     base1, base2;
    logic [FLAG_N-1:0] en, ack, flags, set;
    logic [1:0]        set_emp;
    logic              set_udr;

    pp_regs #(.DW(DW), .ALIGN(ALIGN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .base1(base1), .base2(base2), .en(en), .ack(ack)
    );

    pp_seq #(.DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .consumed(evt_consumed), .need(evt_need),
        .emp(flags[F_EMP2:F_EMP1]), .ack_buf(ack[F_EMP2:F_EMP1]),
        .base1(base1), .base2(base2), .set_emp(set_emp), .set_udr(set_udr),
        .cur_sel(fetch_sel), .fetch_addr(fetch_addr), .fetch_valid(fetch_valid)
    );

    assign set = {set_udr, evt_error, set_emp};

    pp_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set(set), .clr(ack), .flags(flags)
    );

    assign irq_o = |(en & flags);

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL:  reg_rdata[2*FLAG_N-1:FLAG_N] = en;
            A_STAT:  reg_rdata[FLAG_N:0] = {fetch_sel, flags};
            A_BASE1: reg_rdata = base1;
            A_BASE2: reg_rdata = base2;
            default: reg_rdata = '0;
        endcase
    end

    p_irq_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |-> !irq_o);
    p_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_addr[1] |-> (reg_rdata[ALIGN-1:0] == '0));
    p_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_need && !fetch_valid) |=> flags[F_UDR]);
    p_error_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_error |=> flags[F_ERR]);
endmodule

// File: tb/pingpong_buf_ctrl_bench.sv
module pingpong_buf_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_consumed = 1'b0, evt_need = 1'b0, evt_error = 1'b0;
    logic [31:0] fetch_addr;
    logic        fetch_valid, fetch_sel, irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [3:0]  m_flag;
    logic [3:0]  m_en;
    logic [31:0] m_base [2];
    logic [31:0] m_lat [2];
    logic        m_cur;

    always #4 clk = ~clk;

    pingpong_buf_ctrl u_pingpong_buf_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_consumed(evt_consumed), .evt_need(evt_need), .evt_error(evt_error),
        .fetch_addr(fetch_addr), .fetch_valid(fetch_valid),
        .fetch_sel(fetch_sel), .irq_o(irq_o)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(logic [1:0] a);
        case (a)
            2'd0:    return {24'd0, m_en, 4'd0};
            2'd1:    return {27'd0, m_cur, m_flag};
            2'd2:    return m_base[0];
            default: return m_base[1];
        endcase
    endfunction

    function automatic logic exp_irq();
        return |(m_en & m_flag);
    endfunction

    task automatic model_step(logic wr, logic [1:0] a, logic [31:0] d,
                              logic c, logic n, logic e);
        logic [3:0] set, ack;
        logic       swap;
        set  = 4'd0;
        swap = 1'b0;
        if (c && !m_flag[m_cur]) begin set[m_cur] = 1'b1; swap = 1'b1; end
        if (n && m_flag[m_cur]) set[3] = 1'b1;
        if (e) set[2] = 1'b1;
        ack = (wr && a == 2'd0) ? d[3:0] : 4'd0;
        if (ack[0]) m_lat[0] = m_base[0];
        if (ack[1]) m_lat[1] = m_base[1];
        m_flag = set | (m_flag & ~ack);
        if (wr && a == 2'd0) m_en = d[7:4];
        if (wr && a == 2'd2) m_base[0] = d & 32'hFFFF_FFC0;
        if (wr && a == 2'd3) m_base[1] = d & 32'hFFFF_FFC0;
        if (swap) m_cur = ~m_cur;
    endtask

    task automatic check_outs(string tag);
        chk({tag, " R11 fetch_valid"}, 32'(fetch_valid), 32'(!m_flag[m_cur]));
        chk({tag, " R6 fetch_sel"}, 32'(fetch_sel), 32'(m_cur));
        chk({tag, " R5 fetch_addr"}, fetch_addr, m_lat[m_cur]);
        chk({tag, " R9 irq"}, 32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic rd(logic [1:0] a, string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp_read(a));
    endtask

    task automatic cyc(logic wr, logic [1:0] a, logic [31:0] d,
                       logic c, logic n, logic e);
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        evt_consumed = c; evt_need = n; evt_error = e;
        @(posedge clk);
        model_step(wr, a, d, c, n, e);
        #1;
        reg_wr = 1'b0; evt_consumed = 1'b0; evt_need = 1'b0; evt_error = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #1500000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        m_flag = 4'b0011; m_en = 4'd0; m_cur = 1'b0;
        m_base[0] = '0; m_base[1] = '0; m_lat[0] = '0; m_lat[1] = '0;
        seed = 32'h1f2e3d;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd1, "R1 status after reset");
        rd(2'd0, "R1 enables after reset");
        chk("R1 irq", 32'(irq_o), 32'd0);
        chk("R1 fetch_valid", 32'(fetch_valid), 32'd0);
        chk("R1 fetch_sel", 32'(fetch_sel), 32'd0);

        // R4 alignment
        cyc(1, 2'd2, 32'hFFFF_FFFF, 0, 0, 0);
        rd(2'd2, "R4 base1 low bits");
        chk("R4 base1 literal", reg_rdata, 32'hFFFF_FFC0);
        cyc(1, 2'd3, 32'h0000_12BF, 0, 0, 0);
        rd(2'd3, "R4 base2 low bits");

        // R2 and R5: ack buffer 1 latches base
        cyc(1, 2'd0, 32'h0000_0001, 0, 0, 0);
        rd(2'd1, "R2 ack clears buf1 empty");
        chk("R5 latched addr", fetch_addr, 32'hFFFF_FFC0);
        cyc(1, 2'd2, 32'h0000_1000, 0, 0, 0);
        chk("R5 later base write ignored", fetch_addr, 32'hFFFF_FFC0);
        check_outs("R5");

        // R3 ack bits read zero
        cyc(1, 2'd0, 32'h0000_00F0, 0, 0, 0);
        rd(2'd0, "R3 ctrl readback");
        chk("R3 ctrl literal", reg_rdata, 32'h0000_00F0);
        // R2 zero ack bits have no effect
        cyc(1, 2'd0, 32'h0000_0000, 0, 0, 0);
        rd(2'd1, "R2 zero ack no effect");

        // R6 consume buffer 1, then consume empty buffer 2 ignored
        cyc(0, 2'd0, 0, 1, 0, 0);
        check_outs("R6 swap");
        rd(2'd1, "R6 status after swap");
        cyc(0, 2'd0, 0, 1, 0, 0);
        check_outs("R6 hold on empty");

        // R7 underrun
        cyc(0, 2'd0, 0, 0, 1, 0);
        rd(2'd1, "R7 underrun set");
        // R9 irq with underrun enable only
        cyc(1, 2'd0, 32'h0000_0080, 0, 0, 0);
        chk("R9 irq on underrun", 32'(irq_o), 32'd1);
        // R8 error then clears
        cyc(0, 2'd0, 0, 0, 0, 1);
        rd(2'd1, "R8 error set");
        cyc(1, 2'd0, 32'h0000_000C, 0, 0, 0);
        rd(2'd1, "R8 ack clears err and udr");
        chk("R9 irq low after clear", 32'(irq_o), 32'd0);

        // R10 set wins: buffer 2 ack plus consume in same cycle
        cyc(1, 2'd0, 32'h0000_0002, 0, 0, 0);
        check_outs("R10 prep");
        cyc(1, 2'd0, 32'h0000_0002, 1, 0, 0);
        rd(2'd1, "R10 consume beats ack");
        cyc(1, 2'd0, 32'h0000_0004, 0, 0, 1);
        rd(2'd1, "R10 error beats ack");

        // random phase
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  a;
            logic [31:0] d;
            a = 2'($urandom_range(0, 3));
            d = $urandom;
            if (a == 2'd0) d[31:8] = '0;
            cyc($urandom_range(0, 2) == 0, a, d,
                $urandom_range(0, 2) == 0, $urandom_range(0, 3) == 0,
                $urandom_range(0, 7) == 0);
            check_outs("rand");
            rd(2'($urandom_range(0, 3)), "rand R3 R4 readback");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule